// File: doc/BRIEF.md
# Serial Interface Status Flag Register

This block holds the eight status bits of a serial port: transmit buffer empty, receive buffer full, overrun, framing error, parity error, transmit finished, the received multiprocessor bit and the multiprocessor bit to send. The transmitter and receiver report events on single-cycle pulses or level inputs. A CPU bus port reads the whole byte with no wait states and clears flags by writing zeros.

Software may clear a flag only after it has read that flag as 1. Each of the five clearable flags keeps a private arm bit for this purpose. A written 0 with no arm bit behind it does nothing, and a written 1 never sets a flag. If the hardware sets a flag in the same cycle that a valid clearing write reaches it, the hardware event wins. The arm bit is then dropped, so software must read the flag again before it can clear it.

Top module: `serial_status_reg`

## Requirements
- R1: `bus_rdata_o` carries the full register in the same cycle with no wait state. The bit order from bit 7 down to bit 0 is: transmit-empty, receive-full, overrun, framing error, parity error, transmit-end, received multiprocessor bit, multiprocessor transmit bit.
- R2: When `rst` or `standby_i` is high at a clock edge, the register becomes 0x84 (transmit-empty and transmit-end set, all other bits clear) and every arm bit is dropped.
- R3: A bus write of 1 to any of bits 7..3 never sets that flag.
- R4: A bus write of 0 to bit 7, 6, 5, 4 or 3 clears that flag only if a bus read saw the flag at 1 in an earlier cycle since the flag was last cleared. Otherwise the write leaves the flag unchanged.
- R5: Once a flag has been cleared, its arm bit is gone. A later 0 write does not clear the flag after it is set again, until the flag is read as 1 once more.
- R6: Bit 2 follows `tx_end_lvl_i` and bit 1 follows `rx_mpb_lvl_i`, each one clock later. Bus writes to bits 2 and 1 have no effect.
- R7: Bit 7 is set at every edge where `te_i` is low or `tdr_xfer_i` is high.
- R8: If a set event and a valid clearing write hit the same flag at the same edge, the flag stays 1 and its arm bit is dropped. A following 0 write without a new read leaves the flag at 1.
- R9: A one-cycle pulse on `rx_full_i`, `rx_overrun_i`, `rx_frame_err_i` or `rx_parity_err_i` sets bit 6, 5, 4 or 3 respectively.
- R10: Bit 0 is a plain read/write bit that takes `bus_wdata_i[0]` on every bus write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_i | input | 1 | Standby request; reinitializes the register while high |
| te_i | input | 1 | Transmit enable from the control logic |
| tdr_xfer_i | input | 1 | Pulse: transmit data moved into the shifter |
| rx_full_i | input | 1 | Pulse: received byte available |
| rx_overrun_i | input | 1 | Pulse: receive overrun |
| rx_frame_err_i | input | 1 | Pulse: framing error |
| rx_parity_err_i | input | 1 | Pulse: parity error |
| tx_end_lvl_i | input | 1 | Level: transmitter idle after last bit |
| rx_mpb_lvl_i | input | 1 | Level: multiprocessor bit of the last received frame |
| bus_rd_i | input | 1 | CPU read strobe |
| bus_wr_i | input | 1 | CPU write strobe |
| bus_wdata_i | input | 8 | CPU write data |
| bus_rdata_o | output | 8 | CPU read data |
| status_o | output | 8 | Registered flag byte for the serial logic |

## Verification
Directed sequences first separate a 0 write with no prior read from a 0 write after a read. They then separate a write of 1s from a write of 0s, and a set pulse that collides with a clearing write from one that arrives alone. Holding `te_i` low while software clears transmit-empty shows the level-type set condition winning on every edge. A long pseudo-random sweep mixes reads, writes of arbitrary bytes, event pulses, level changes and occasional standby. It compares every cycle against an arithmetic flag-and-arm model, which exposes ordering mistakes between reads, sets and clears.

// File: rtl/ssr_pkg.sv
package ssr_pkg;
  localparam int unsigned SSR_W    = 8;
  localparam int unsigned NUM_CLR  = 5;
  localparam int unsigned CLR_LSB  = 3;
  localparam int unsigned B_TXE    = 7;
  localparam int unsigned B_RXF    = 6;
  localparam int unsigned B_OVR    = 5;
  localparam int unsigned B_FRM    = 4;
  localparam int unsigned B_PAR    = 3;
  localparam int unsigned B_TEND   = 2;
  localparam int unsigned B_MPB    = 1;
  localparam int unsigned B_MPBT   = 0;
  localparam logic [SSR_W-1:0] INIT_VAL = 8'h84;
endpackage

// File: rtl/ssr_flag_cell.sv
module ssr_flag_cell #(
  parameter logic INIT_BIT = 1'b0
) (
  input  logic clk,
  input  logic init_i,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic armed_q;
  logic rd_hit;
  logic clr_ok;

  // a read that sees the flag high arms it; a 0 write needs the arm
  assign rd_hit = rd_i & flag_o;
  assign clr_ok = wr_i & ~wbit_i & armed_q;

  always_ff @(posedge clk) begin
    if (init_i) begin
      flag_o  <= INIT_BIT;
      armed_q <= 1'b0;
    end else if (set_i) begin
      flag_o  <= 1'b1;
      armed_q <= clr_ok ? 1'b0 : (armed_q | rd_hit);
    end else if (clr_ok) begin
      flag_o  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      armed_q <= armed_q | rd_hit;
    end
  end
endmodule

// File: rtl/ssr_plain_bit.sv
module ssr_plain_bit #(
  parameter bit   WRITABLE = 1'b0,
  parameter logic INIT_BIT = 1'b0
) (
  input  logic clk,
  input  logic init_i,
  input  logic lvl_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic bit_o
);
  logic nxt;

  // writable variant keeps its value between writes; level variant tracks lvl_i
  assign nxt = WRITABLE ? (wr_i ? wbit_i : bit_o) : lvl_i;

  always_ff @(posedge clk) begin
    if (init_i) bit_o <= INIT_BIT;
    else        bit_o <= nxt;
  end
endmodule

// File: rtl/serial_status_reg.sv
module serial_status_reg
  import ssr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             standby_i,
  input  logic             te_i,
  input  logic             tdr_xfer_i,
  input  logic             rx_full_i,
  input  logic             rx_overrun_i,
  input  logic             rx_frame_err_i,
  input  logic             rx_parity_err_i,
  input  logic             tx_end_lvl_i,
  input  logic             rx_mpb_lvl_i,
  input  logic             bus_rd_i,
  input  logic             bus_wr_i,
  input  logic [SSR_W-1:0] bus_wdata_i,
  output logic [SSR_W-1:0] bus_rdata_o,
  output logic [SSR_W-1:0] status_o
);
  logic               init;
  logic [NUM_CLR-1:0] set_vec;

  assign init = rst | standby_i;

  // index j of set_vec drives status bit CLR_LSB+j
  assign set_vec[B_TXE-CLR_LSB] = ~te_i | tdr_xfer_i;
  assign set_vec[B_RXF-CLR_LSB] = rx_full_i;
  assign set_vec[B_OVR-CLR_LSB] = rx_overrun_i;
  assign set_vec[B_FRM-CLR_LSB] = rx_frame_err_i;
  assign set_vec[B_PAR-CLR_LSB] = rx_parity_err_i;

  for (genvar j = 0; j < NUM_CLR; j++) begin : g_clr
    ssr_flag_cell #(.INIT_BIT(INIT_VAL[CLR_LSB+j])) u_cell (
      .clk    (clk),
      .init_i (init),
      .set_i  (set_vec[j]),
      .rd_i   (bus_rd_i),
      .wr_i   (bus_wr_i),
      .wbit_i (bus_wdata_i[CLR_LSB+j]),
      .flag_o (status_o[CLR_LSB+j])
    );
  end

  ssr_plain_bit #(.WRITABLE(1'b0), .INIT_BIT(INIT_VAL[B_TEND])) u_tend (
    .clk(clk), .init_i(init), .lvl_i(tx_end_lvl_i),
    .wr_i(bus_wr_i), .wbit_i(bus_wdata_i[B_TEND]), .bit_o(status_o[B_TEND])
  );

  ssr_plain_bit #(.WRITABLE(1'b0), .INIT_BIT(INIT_VAL[B_MPB])) u_mpb (
    .clk(clk), .init_i(init), .lvl_i(rx_mpb_lvl_i),
    .wr_i(bus_wr_i), .wbit_i(bus_wdata_i[B_MPB]), .bit_o(status_o[B_MPB])
  );

  ssr_plain_bit #(.WRITABLE(1'b1), .INIT_BIT(INIT_VAL[B_MPBT])) u_mpbt (
    .clk(clk), .init_i(init), .lvl_i(1'b0),
    .wr_i(bus_wr_i), .wbit_i(bus_wdata_i[B_MPBT]), .bit_o(status_o[B_MPBT])
  );

  assign bus_rdata_o = status_o;
endmodule

// File: rtl/ssr_checker.sv
module ssr_checker (
  input logic       clk,
  input logic       rst,
  input logic       standby_i,
  input logic       te_i,
  input logic       tdr_xfer_i,
  input logic       rx_full_i,
  input logic       tx_end_lvl_i,
  input logic       rx_mpb_lvl_i,
  input logic       bus_wr_i,
  input logic [7:0] bus_wdata_i,
  input logic [7:0] status_o
);
  p_init_value_r2: assert property (@(posedge clk) disable iff (rst)
    standby_i |=> status_o == 8'h84);

  p_no_set_by_write_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[6]) |-> $past(rx_full_i));

  p_clear_needs_write_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(status_o[6]) && !$past(standby_i) && !$past(rst))
      |-> $past(bus_wr_i && !bus_wdata_i[6]));

  p_tend_follows_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(standby_i) && !$past(rst)) |-> status_o[2] == $past(tx_end_lvl_i));

  p_mpb_follows_r6: assert property (@(posedge clk) disable iff (rst)
    (!$past(standby_i) && !$past(rst)) |-> status_o[1] == $past(rx_mpb_lvl_i));

  p_txe_set_r7: assert property (@(posedge clk) disable iff (rst)
    (!te_i || tdr_xfer_i) |=> status_o[7]);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_full_i && !standby_i) |=> status_o[6]);
endmodule

bind serial_status_reg ssr_checker u_ssr_chk (.*);

// File: tb/tb_serial_status_reg.sv
module tb_serial_status_reg;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       standby_i = 1'b0;
  logic       te_i = 1'b1;
  logic       tdr_xfer_i = 1'b0;
  logic       rx_full_i = 1'b0;
  logic       rx_overrun_i = 1'b0;
  logic       rx_frame_err_i = 1'b0;
  logic       rx_parity_err_i = 1'b0;
  logic       tx_end_lvl_i = 1'b1;
  logic       rx_mpb_lvl_i = 1'b0;
  logic       bus_rd_i = 1'b0;
  logic       bus_wr_i = 1'b0;
  logic [7:0] bus_wdata_i = 8'h00;
  logic [7:0] bus_rdata_o;
  logic [7:0] status_o;

  int   n_chk = 0;
  int   n_fail = 0;
  logic done = 1'b0;

  logic [7:0] m_st = 8'h84;
  logic [4:0] m_arm = 5'b0;

  always #4 clk = ~clk;

  serial_status_reg dut (.*);

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // arithmetic model of the next register value from the current inputs
  task automatic model_step();
    logic [7:0] n;
    logic [4:0] sv;
    logic       hit;
    logic       ok;
    if (rst || standby_i) begin
      m_st  = 8'h84;
      m_arm = 5'b0;
    end else begin
      n  = m_st;
      sv = {~te_i | tdr_xfer_i, rx_full_i, rx_overrun_i, rx_frame_err_i, rx_parity_err_i};
      for (int j = 0; j < 5; j++) begin
        hit = bus_rd_i & m_st[3+j];
        ok  = bus_wr_i & ~bus_wdata_i[3+j] & m_arm[j];
        if (sv[j]) begin
          n[3+j]   = 1'b1;
          m_arm[j] = ok ? 1'b0 : (m_arm[j] | hit);
        end else if (ok) begin
          n[3+j]   = 1'b0;
          m_arm[j] = 1'b0;
        end else begin
          m_arm[j] = m_arm[j] | hit;
        end
      end
      n[2] = tx_end_lvl_i;
      n[1] = rx_mpb_lvl_i;
      if (bus_wr_i) n[0] = bus_wdata_i[0];
      m_st = n;
    end
  endtask

  task automatic tick(input string tag);
    model_step();
    @(negedge clk);
    check(tag, status_o, m_st);
    check("R1 rdata", bus_rdata_o, m_st);
    bus_rd_i = 1'b0; bus_wr_i = 1'b0; tdr_xfer_i = 1'b0;
    rx_full_i = 1'b0; rx_overrun_i = 1'b0; rx_frame_err_i = 1'b0; rx_parity_err_i = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d, input string tag);
    bus_wr_i = 1'b1; bus_wdata_i = d; tick(tag);
  endtask

  task automatic rd(input string tag);
    bus_rd_i = 1'b1; tick(tag);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [15:0] lf;
    @(negedge clk);
    tick("R2 reset");
    tick("R2 reset");
    rst = 1'b0;
    check("R2 reset value", status_o, 8'h84);

    rx_full_i = 1; rx_overrun_i = 1; rx_frame_err_i = 1; rx_parity_err_i = 1;
    tick("R9 pulses");
    check("R9 receiver flags", status_o, 8'hFC);

    wr(8'hFF, "R3 write ones");
    check("R3 ones ignored", status_o, 8'hFD);
    wr(8'h00, "R4 unarmed");
    check("R4 unarmed zero write", status_o, 8'hFC);
    rd("R4 read");
    wr(8'hF7, "R4 armed");
    check("R4 armed clear of bit3", status_o, 8'hF5);

    rx_parity_err_i = 1; tick("R5 reset flag");
    wr(8'hF7, "R5 no rearm");
    check("R5 clear needs new read", status_o, 8'hFD);

    bus_rd_i = 1; bus_wr_i = 1; bus_wdata_i = 8'h00; rx_full_i = 1;
    tick("R8 collide");
    check("R8 set wins", status_o, 8'h4C);
    wr(8'h00, "R8 arm dropped");
    check("R8 arm dropped", status_o, 8'h44);
    rd("R8 reread");
    wr(8'h00, "R8 clear");
    check("R8 clear after reread", status_o, 8'h04);

    tdr_xfer_i = 1; tick("R7 xfer");
    check("R7 transfer sets bit7", status_o, 8'h84);
    rd("R7 read"); wr(8'h00, "R7 clear");
    check("R7 cleared", status_o, 8'h04);
    te_i = 0; tick("R7 te low");
    check("R7 te low sets bit7", status_o, 8'h84);
    rd("R7 read te low"); wr(8'h00, "R7 clear te low");
    check("R7 te low holds bit7", status_o, 8'h84);
    te_i = 1; tick("R7 te high");

    tx_end_lvl_i = 0; tick("R6 tend");
    check("R6 tend follows", status_o, 8'h80);
    rx_mpb_lvl_i = 1; tick("R6 mpb");
    check("R6 mpb follows", status_o, 8'h82);
    wr(8'hFF, "R6 write");
    check("R6 ro bits kept on ones", status_o, 8'h83);
    wr(8'h00, "R6 write");
    check("R6 ro bits kept on zeros", status_o, 8'h82);
    tx_end_lvl_i = 1; rx_mpb_lvl_i = 0; tick("R6 restore");

    wr(8'h01, "R10 set");
    check("R10 mpbt set", status_o, 8'h85);
    wr(8'h00, "R10 clear");
    check("R10 mpbt clear", status_o, 8'h84);

    rx_overrun_i = 1; tick("R2 pre");
    check("R9 overrun", status_o, 8'hA4);
    standby_i = 1; rx_full_i = 1; tick("R2 standby");
    check("R2 standby value", status_o, 8'h84);
    standby_i = 0; tick("R2 after standby");

    lf = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      for (int s = 0; s < 8; s++) lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      bus_rd_i        = lf[0];
      bus_wr_i        = lf[1] & lf[2];
      bus_wdata_i     = lf[15:8];
      rx_full_i       = lf[3] & lf[4];
      rx_overrun_i    = lf[5] & lf[6] & lf[3];
      rx_frame_err_i  = lf[7] & lf[9];
      rx_parity_err_i = lf[11] & lf[12] & lf[13];
      tdr_xfer_i      = lf[14] & lf[4];
      te_i            = (lf[6:4] != 3'b000);
      tx_end_lvl_i    = lf[10];
      rx_mpb_lvl_i    = lf[8];
      standby_i       = (lf[15:10] == 6'd0);
      tick("R4 sweep");
    end
    standby_i = 0; te_i = 1;

    done = 1'b1;
    finish_run();
  end
endmodule